// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block raises a processor interrupt after a chosen number of rendered picture lines. It watches bit 12 of the video address bus. During rendering, that bit rises once per line after a long low stretch, so each filtered rising edge counts as one line clock. An 8-bit down-counter is reloaded from a latch that software writes. When the counter reaches zero with interrupts enabled, a pending flag is set. The flag drives an active-low interrupt line, and that line stays asserted until software acknowledges it.

Software uses four write-only registers, selected by the CPU address masked with 0xE001:

- a latch value;
- a reload request;
- a disable that also acknowledges;
- an enable.

Everything runs in the CPU clock domain. The A12 input must already be synchronised to that clock. The `render_en` input gates line clocks, so the counter stops during vertical blank and while rendering is off.

Top module: `scanline_irq`

## Requirements
- R1: After reset, `irq_n` is 1, the counter and latch are 0 and interrupts are disabled.
- R2: A write is decoded from `cpu_addr & 16'hE001`. The codes are: 0xC000 writes the latch, 0xC001 requests a reload, 0xE000 disables and acknowledges, 0xE001 enables. Any address that masks to one of these codes acts as that register.
- R3: On each line clock, a counter at zero is loaded from the latch. A counter that is not zero is decremented by one.
- R4: After a line clock updates the counter, a result of zero sets the pending flag, but only if interrupts are enabled. No flag is set while interrupts are disabled.
- R5: With a latch of 0, every line clock sets the pending flag while interrupts are enabled.
- R6: A reload write sets the counter to 0, so the next line clock loads the latch. With latch L, the flag is therefore set on the (L+1)-th clock after the reload write.
- R7: A disable write clears the pending flag and disables interrupts. An enable write only enables; it neither sets nor clears the flag.
- R8: A line clock occurs only when A12 is sampled high after it was sampled low on at least LOW_MIN (3) consecutive clock edges. Shorter low stretches produce no clock.
- R9: While `render_en` is 0, a rising A12 produces no line clock.
- R10: `irq_n` goes low on the edge after the clock that sets the flag. It stays low until a disable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | CNT_W | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one write per high cycle |
| ppu_a12 | input | 1 | Video address bit 12, synchronised to `clk` |
| render_en | input | 1 | High while visible lines are being rendered |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench sweeps latch values 0 to 9. After each reload it applies line pulses and compares `irq_n` after every pulse with an arithmetic model. This separates an early or late reload (off-by-one in the L+1 timing) from a wrong decrement.

A12 low stretches of 1, 2 and 3 cycles show where the filter threshold lies. Line pulses with rendering off, and with interrupts disabled, show that the counter and the flag are gated separately. Mirrored register addresses confirm that the mask decode works. Enable writes made while the flag is pending show that only the disable register clears the flag.

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int CNT_W   = 8,
  parameter int LOW_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cpu_addr,
  input  logic [CNT_W-1:0] cpu_data,
  input  logic             cpu_we,
  input  logic             ppu_a12,
  input  logic             render_en,
  output logic             irq_n
);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam logic [LW-1:0] LOW_SAT = LW'(LOW_MIN);

  logic [15:0]      reg_sel;
  logic [LW-1:0]    low_cnt;
  logic [CNT_W-1:0] cnt, latch, cnt_nxt;
  logic             irq_en, pending, tick;
  logic             wr_latch, wr_reload, wr_off, wr_on;

  assign reg_sel   = cpu_addr & 16'hE001;
  assign wr_latch  = cpu_we && reg_sel == 16'hC000;
  assign wr_reload = cpu_we && reg_sel == 16'hC001;
  assign wr_off    = cpu_we && reg_sel == 16'hE000;
  assign wr_on     = cpu_we && reg_sel == 16'hE001;

  assign tick    = ppu_a12 && render_en && low_cnt == LOW_SAT;
  assign cnt_nxt = (cnt == '0) ? latch : cnt - 1'b1;
  assign irq_n   = ~pending;

  always_ff @(posedge clk) begin
    if (!rst_n)
      low_cnt <= '0;
    else if (ppu_a12)
      low_cnt <= '0;
    else if (low_cnt != LOW_SAT)
      low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      latch   <= '0;
      irq_en  <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (wr_latch)
        latch <= cpu_data;
      if (wr_reload)
        cnt <= '0;
      else if (tick)
        cnt <= cnt_nxt;
      if (wr_off)
        irq_en <= 1'b0;
      else if (wr_on)
        irq_en <= 1'b1;
      if (wr_off)
        pending <= 1'b0;
      else if (tick && !wr_reload && cnt_nxt == '0 && irq_en)
        pending <= 1'b1;
    end
  end
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [15:0]      cpu_addr,
  input logic             cpu_we,
  input logic             ppu_a12,
  input logic             render_en,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic             irq_en,
  input logic             pending,
  input logic             irq_n
);
  logic ack_wr, rld_wr;
  assign ack_wr = cpu_we && (cpu_addr & 16'hE001) == 16'hE000;
  assign rld_wr = cpu_we && (cpu_addr & 16'hE001) == 16'hC001;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> irq_n && cnt == '0);

  // R3
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !rld_wr && cnt != '0 |=> cnt == $past(cnt) - 1'b1);

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en && !pending |=> !pending);

  // R6
  reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rld_wr |=> cnt == '0);

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> irq_n);

  // R8
  edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !$past(ppu_a12));

  // R9
  render_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !render_en && !rld_wr |=> $stable(cnt));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n && !ack_wr |=> !irq_n);
endmodule

bind scanline_irq scanline_irq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .ppu_a12(ppu_a12), .render_en(render_en), .tick(tick), .cnt(cnt),
  .irq_en(irq_en), .pending(pending), .irq_n(irq_n)
);

// File: tb/scanline_irq_tb.sv
module scanline_irq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_we = 1'b0;
  logic        ppu_a12 = 1'b0;
  logic        render_en = 1'b1;
  logic        irq_n;

  int checks = 0, fails = 0;
  int m_cnt = 0, m_lat = 0;
  bit m_en = 0, m_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanline_irq dut_i (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cpu_we(cpu_we), .ppu_a12(ppu_a12),
    .render_en(render_en), .irq_n(irq_n));

  task automatic check(string req, logic exp);
    checks++;
    if (irq_n !== exp) begin
      fails++;
      $display("FAIL %s: irq_n=%b expected %b", req, irq_n, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
    case (a & 16'hE001)
      16'hC000: m_lat = d;
      16'hC001: m_cnt = 0;
      16'hE000: begin m_en = 0; m_pend = 0; end
      16'hE001: m_en = 1;
      default: ;
    endcase
  endtask

  task automatic line(int lows);
    @(negedge clk);
    ppu_a12 = 1'b0;
    repeat (lows) @(negedge clk);
    ppu_a12 = 1'b1;
    @(negedge clk);
    ppu_a12 = 1'b1;
    if (lows >= 3 && render_en) begin
      m_cnt = (m_cnt == 0) ? m_lat : m_cnt - 1;
      if (m_cnt == 0 && m_en) m_pend = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b1);
    line(3);
    check("R1", 1'b1);

    // R3 R6 R2: sweep latch values, mirrored addresses on odd values
    for (int l = 0; l < 10; l++) begin
      wr((l % 2) ? 16'hFFFE : 16'hE000, 8'h00);
      wr((l % 2) ? 16'hDEFE : 16'hC000, 8'(l));
      wr((l % 2) ? 16'hDFFF : 16'hC001, 8'h00);
      wr((l % 2) ? 16'hE0A1 : 16'hE001, 8'h00);
      for (int k = 1; k <= 2 * l + 3; k++) begin
        line(4);
        check((k == l + 1) ? "R6" : "R3", !m_pend);
        check("R2", (k >= l + 1) ? 1'b0 : 1'b1);
      end
    end

    // R10 R7: held until disable; enable does not clear
    wr(16'hE001, 8'h00);
    check("R10", 1'b0);
    line(3);
    check("R10", !m_pend);
    wr(16'hE000, 8'h00);
    check("R7", 1'b1);

    // R5: latch 0 raises on every clock
    wr(16'hC000, 8'h00);
    wr(16'hC001, 8'h00);
    wr(16'hE001, 8'h00);
    for (int k = 0; k < 4; k++) begin
      line(3);
      check("R5", 1'b0);
      wr(16'hE000, 8'h00);
      wr(16'hE001, 8'h00);
      check("R5", 1'b1);
    end

    // R8: short low stretches give no clock
    for (int lw = 1; lw <= 3; lw++) begin
      line(lw);
      check("R8", (lw >= 3) ? 1'b0 : 1'b1);
    end
    wr(16'hE000, 8'h00);

    // R9: rendering off suppresses clocks
    wr(16'hE001, 8'h00);
    render_en = 1'b0;
    line(5);
    check("R9", 1'b1);
    render_en = 1'b1;
    line(5);
    check("R9", 1'b0);

    // R4: disabled, counter still runs but no flag; enable alone sets nothing
    wr(16'hE000, 8'h00);
    wr(16'hC000, 8'd2);
    wr(16'hC001, 8'h00);
    for (int k = 0; k < 4; k++) begin
      line(3);
      check("R4", 1'b1);
    end
    wr(16'hE001, 8'h00);
    check("R7", 1'b1);
    // counter sequence: 2,1,0,2 -> next 1, then 0 raises
    line(3);
    check("R4", !m_pend);
    line(3);
    check("R4", !m_pend);
    check("R4", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule